// File: doc/BRIEF.md
# I2C Target Controller with Access Status Flags

This block is the target (slave) end of a two-wire I2C bus. It watches the
open-drain clock and data lines through a synchronizer running on the
system clock. It recognises START, repeated START and STOP conditions, and
decodes the 7-bit address that follows every START. It acknowledges only an
address equal to the value on its `own_addr` input. A matching master write
places each received byte in a receive holding register. A matching master
read is served from a transmit holding register, which the local processor
loads through a one-cycle write strobe.

The local processor sees a small set of status flags. `acc_active` marks an
ongoing access to this target and stays set across repeated STARTs that
name the same address. `acc_dir` gives the direction of that access.
`acc_end` is a one-cycle pulse that marks the end of an access. `rx_rdy`
and `tx_rdy` follow the movement of bytes between the holding registers and
the shift register. `rx_ovr` reports a receive byte that was overwritten
before it was read.

The block drives SDA through `sda_oe`. When this output is high, the pad
pulls the line low. The block never drives SCL. It has no clock stretching,
so the processor must service the holding registers within one byte time.

Top module: `i2c_target_ctrl`

## Requirements
- R1: After reset, `acc_active`, `acc_end`, `rx_rdy`, `rx_ovr` and `sda_oe` are 0, and `tx_rdy` is 1.
- R2: Address decoding starts after every START and after every repeated START. The first byte after the condition is taken MSB first as 7 address bits followed by a direction bit (0 = master writes, 1 = master reads). When the 7 address bits equal `own_addr`, the target pulls SDA low in the ninth clock, sets `acc_active`, and sets `acc_dir` to the direction bit.
- R3: A non-matching address gets no acknowledge: SDA stays released in the ninth clock. It does not set `acc_active`, and the target leaves the bus alone until the next START or STOP.
- R4: During a matched master write, each byte is shifted in MSB first and acknowledged. After its eighth bit it is copied into `rx_data`, and `rx_rdy` is set. A one-cycle `rd_rx` pulse clears `rx_rdy`.
- R5: A byte that completes while `rx_rdy` is still set replaces `rx_data` and sets `rx_ovr`. A one-cycle `rd_stat` pulse clears `rx_ovr`. `rx_ovr` is never set without `rx_rdy` being set.
- R6: During a matched master read, the holding byte is loaded into the shift register on the SCL fall that ends the preceding acknowledge. The byte is sent MSB first. `tx_rdy` clears at the load and sets again when the master's acknowledge bit is sampled, whether that bit is ACK or NACK. `tx_rdy` falls only while a read access is active.
- R7: A byte written with `wr_tx` is sent by the next load. If nothing was written since the previous load, the target sends 0xFF.
- R8: A master NACK after a read byte ends the data phase. SDA stays released until the next START, repeated START or STOP.
- R9: `acc_active` clears on a STOP, and on a repeated START whose address does not match. In either case `acc_end` pulses for exactly one cycle. A repeated START to the same address keeps `acc_active` set, raises no `acc_end`, and updates `acc_dir`. A STOP with no access active raises no `acc_end`.
- R10: `sda_oe` only goes from released to driving while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| own_addr | input | 7 | Address this target answers to |
| scl_i | input | 1 | SCL line level from the pad |
| sda_i | input | 1 | SDA line level from the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| wr_tx | input | 1 | One-cycle strobe writing `tx_data` into the transmit holding register |
| tx_data | input | 8 | Byte for the next master read |
| rd_rx | input | 1 | One-cycle strobe marking `rx_data` as consumed |
| rx_data | output | 8 | Receive holding register |
| rd_stat | input | 1 | One-cycle strobe marking the status as read (clears overrun) |
| acc_active | output | 1 | Access to this target in progress |
| acc_dir | output | 1 | 1 = master reads, 0 = master writes; meaningful only while `acc_active` is 1 |
| acc_end | output | 1 | One-cycle pulse when an access ends |
| rx_rdy | output | 1 | Receive holding register holds an unread byte |
| tx_rdy | output | 1 | Transmit holding register free for a new byte |
| rx_ovr | output | 1 | Unread receive byte was overwritten |

## Verification
On every cycle, the assertions check several rules. `acc_end` lasts one cycle and follows an active access. `rx_rdy` only rises during a write access, and `tx_rdy` only falls during a read access. An overrun never appears without a pending byte. The target only starts pulling SDA while SCL is low. The bench's master scenarios are needed for the rest: that the address is compared with `own_addr`, the bit order of data in both directions, and the 0xFF fill when no byte was written. They also show whether the access flag survives a repeated START to the same address, and whether it drops on a repeated START to a different one.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ACK,
      ST_RX,
      ST_TX,
      ST_TXACK,
      ST_TXNEXT,
      ST_HOLD
   } tgt_state_e;

   // per-cycle events from the bit engine to the register side
   typedef struct packed {
      logic rx_push;
      logic tx_load;
      logic tx_done;
      logic acc_set;
      logic acc_rd;
      logic stop_evt;
      logic addr_miss;
   } tgt_evt_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_raw,
   input  logic sda_raw,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic [STAGES-1:0] scl_chain;
   logic [STAGES-1:0] sda_chain;
   logic              scl_q;
   logic              sda_q;

   initial begin
      if (STAGES < 2) $fatal(1, "i2c_line_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_chain[i] <= 1'b1;
               sda_chain[i] <= 1'b1;
            end else begin
               scl_chain[i] <= scl_raw;
               sda_chain[i] <= sda_raw;
            end
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_chain[i] <= 1'b1;
               sda_chain[i] <= 1'b1;
            end else begin
               scl_chain[i] <= scl_chain[i-1];
               sda_chain[i] <= sda_chain[i-1];
            end
         end
      end
   end

   assign scl_s = scl_chain[STAGES-1];
   assign sda_s = sda_chain[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise  = ~scl_q & scl_s;
   assign scl_fall  = scl_q & ~scl_s;
   assign start_det = scl_q & scl_s & sda_q & ~sda_s;
   assign stop_det  = scl_q & scl_s & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
   import i2c_tgt_pkg::*;
#(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic [DATA_W-1:0] tx_byte,
   output logic [DATA_W-1:0] rx_byte,
   output tgt_evt_t          evt,
   output logic              sda_oe
);

   localparam int CNT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
   localparam logic [CNT_W-1:0] ALL_BITS = CNT_W'(DATA_W);

   tgt_state_e        state;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] sh;
   logic [1:0]        ack_ph;
   logic              rd_mode;
   logic              oe_q;

   logic [DATA_W-1:0] byte_in;
   logic              addr_done;
   logic              addr_hit;
   logic              load_now;

   initial begin
      if (ADDR_W + 1 != DATA_W)
         $fatal(1, "i2c_tgt_engine: address plus direction must fill one byte");
   end

   assign byte_in   = {sh[DATA_W-2:0], sda_s};
   assign addr_done = (state == ST_ADDR) && scl_rise && (cnt == LAST_BIT);
   assign addr_hit  = (byte_in[DATA_W-1:1] == own_addr);
   assign load_now  = scl_fall &&
                      ((state == ST_TXNEXT) ||
                       ((state == ST_ACK) && (ack_ph == 2'd2) && rd_mode));

   always_comb begin
      evt           = '0;
      evt.acc_set   = addr_done && addr_hit;
      evt.acc_rd    = byte_in[0];
      evt.addr_miss = addr_done && !addr_hit;
      evt.rx_push   = (state == ST_RX) && scl_rise && (cnt == LAST_BIT);
      evt.tx_load   = load_now;
      evt.tx_done   = (state == ST_TXACK) && scl_rise;
      evt.stop_evt  = stop_det;
   end

   assign rx_byte = byte_in;
   assign sda_oe  = oe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         sh      <= '0;
         ack_ph  <= 2'd0;
         rd_mode <= 1'b0;
         oe_q    <= 1'b0;
      end else if (start_det) begin
         state <= ST_ADDR;
         cnt   <= '0;
         oe_q  <= 1'b0;
      end else if (stop_det) begin
         state <= ST_IDLE;
         oe_q  <= 1'b0;
      end else begin
         unique case (state)
            ST_ADDR: begin
               if (scl_rise) begin
                  sh  <= byte_in;
                  cnt <= cnt + 1'b1;
                  if (cnt == LAST_BIT) begin
                     if (addr_hit) begin
                        state   <= ST_ACK;
                        ack_ph  <= 2'd0;
                        rd_mode <= byte_in[0];
                     end else begin
                        state <= ST_HOLD;
                     end
                  end
               end
            end
            ST_ACK: begin
               unique case (ack_ph)
                  2'd0: if (scl_fall) begin
                     oe_q   <= 1'b1;
                     ack_ph <= 2'd1;
                  end
                  2'd1: if (scl_rise) ack_ph <= 2'd2;
                  default: if (scl_fall) begin
                     cnt <= '0;
                     if (rd_mode) begin
                        sh    <= tx_byte;
                        oe_q  <= ~tx_byte[DATA_W-1];
                        state <= ST_TX;
                     end else begin
                        oe_q  <= 1'b0;
                        state <= ST_RX;
                     end
                  end
               endcase
            end
            ST_RX: begin
               if (scl_rise) begin
                  sh  <= byte_in;
                  cnt <= cnt + 1'b1;
                  if (cnt == LAST_BIT) begin
                     state  <= ST_ACK;
                     ack_ph <= 2'd0;
                  end
               end
            end
            ST_TX: begin
               if (scl_rise) begin
                  cnt <= cnt + 1'b1;
               end else if (scl_fall) begin
                  if (cnt == ALL_BITS) begin
                     oe_q  <= 1'b0;
                     state <= ST_TXACK;
                  end else begin
                     sh   <= {sh[DATA_W-2:0], 1'b0};
                     oe_q <= ~sh[DATA_W-2];
                  end
               end
            end
            ST_TXACK: begin
               if (scl_rise) state <= sda_s ? ST_HOLD : ST_TXNEXT;
            end
            ST_TXNEXT: begin
               if (scl_fall) begin
                  cnt   <= '0;
                  sh    <= tx_byte;
                  oe_q  <= ~tx_byte[DATA_W-1];
                  state <= ST_TX;
               end
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs
   import i2c_tgt_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  tgt_evt_t          evt,
   input  logic [DATA_W-1:0] rx_byte,
   output logic [DATA_W-1:0] tx_byte,
   input  logic              wr_tx,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              rd_rx,
   input  logic              rd_stat,
   output logic [DATA_W-1:0] rx_data,
   output logic              acc_active,
   output logic              acc_dir,
   output logic              acc_end,
   output logic              rx_rdy,
   output logic              tx_rdy,
   output logic              rx_ovr
);

   localparam logic [DATA_W-1:0] FILL = '1;

   logic [DATA_W-1:0] thr;
   logic              thr_fresh;

   assign tx_byte = thr_fresh ? thr : FILL;

   // receive side
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data <= '0;
         rx_rdy  <= 1'b0;
         rx_ovr  <= 1'b0;
      end else begin
         if (evt.rx_push) begin
            rx_data <= rx_byte;
            rx_rdy  <= 1'b1;
         end else if (rd_rx) begin
            rx_rdy <= 1'b0;
         end
         if (evt.rx_push && rx_rdy && !rd_rx) rx_ovr <= 1'b1;
         else if (rd_stat)                    rx_ovr <= 1'b0;
      end
   end

   // transmit side
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr       <= '0;
         thr_fresh <= 1'b0;
         tx_rdy    <= 1'b1;
      end else begin
         if (wr_tx) begin
            thr       <= tx_data;
            thr_fresh <= 1'b1;
         end else if (evt.tx_load) begin
            thr_fresh <= 1'b0;
         end
         if (evt.tx_load)      tx_rdy <= 1'b0;
         else if (evt.tx_done) tx_rdy <= 1'b1;
      end
   end

   // access tracking
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_active <= 1'b0;
         acc_dir    <= 1'b0;
         acc_end    <= 1'b0;
      end else begin
         acc_end <= acc_active && (evt.stop_evt || evt.addr_miss);
         if (evt.acc_set) begin
            acc_active <= 1'b1;
            acc_dir    <= evt.acc_rd;
         end else if (evt.stop_evt || evt.addr_miss) begin
            acc_active <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/i2c_target_ctrl.sv
module i2c_target_ctrl
   import i2c_tgt_pkg::*;
#(
   parameter int ADDR_W      = 7,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic              wr_tx,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              rd_rx,
   output logic [DATA_W-1:0] rx_data,
   input  logic              rd_stat,
   output logic              acc_active,
   output logic              acc_dir,
   output logic              acc_end,
   output logic              rx_rdy,
   output logic              tx_rdy,
   output logic              rx_ovr
);

   logic              scl_sync;
   logic              sda_sync;
   logic              scl_rise;
   logic              scl_fall;
   logic              start_det;
   logic              stop_det;
   logic [DATA_W-1:0] rx_byte;
   logic [DATA_W-1:0] tx_byte;
   tgt_evt_t          evt;

   i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_raw   (scl_i),
      .sda_raw   (sda_i),
      .scl_s     (scl_sync),
      .sda_s     (sda_sync),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2c_tgt_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .own_addr  (own_addr),
      .sda_s     (sda_sync),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .tx_byte   (tx_byte),
      .rx_byte   (rx_byte),
      .evt       (evt),
      .sda_oe    (sda_oe)
   );

   i2c_tgt_regs #(.DATA_W(DATA_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt        (evt),
      .rx_byte    (rx_byte),
      .tx_byte    (tx_byte),
      .wr_tx      (wr_tx),
      .tx_data    (tx_data),
      .rd_rx      (rd_rx),
      .rd_stat    (rd_stat),
      .rx_data    (rx_data),
      .acc_active (acc_active),
      .acc_dir    (acc_dir),
      .acc_end    (acc_end),
      .rx_rdy     (rx_rdy),
      .tx_rdy     (tx_rdy),
      .rx_ovr     (rx_ovr)
   );

endmodule

// File: rtl/i2c_tgt_checker.sv
module i2c_tgt_checker (
   input logic clk,
   input logic rst_n,
   input logic scl_s,
   input logic sda_oe,
   input logic acc_active,
   input logic acc_dir,
   input logic acc_end,
   input logic rx_rdy,
   input logic tx_rdy,
   input logic rx_ovr
);

   p_end_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      acc_end |=> !acc_end);

   p_end_after_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
      acc_end |-> ($past(acc_active) && !acc_active));

   p_drive_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_s);

   p_ovr_needs_rdy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_ovr) |-> rx_rdy);

   p_rxrdy_in_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_rdy) |-> (acc_active && !acc_dir));

   p_txrdy_fall_in_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_rdy) |-> (acc_active && acc_dir));

endmodule

bind i2c_target_ctrl i2c_tgt_checker u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .scl_s      (scl_sync),
   .sda_oe     (sda_oe),
   .acc_active (acc_active),
   .acc_dir    (acc_dir),
   .acc_end    (acc_end),
   .rx_rdy     (rx_rdy),
   .tx_rdy     (tx_rdy),
   .rx_ovr     (rx_ovr)
);

// File: tb/test_i2c_target_ctrl.sv
`timescale 1ns/1ps
module test_i2c_target_ctrl;

   localparam int Q = 16;              // quarter SCL period in clk cycles
   localparam logic [6:0] MY_ADDR = 7'h3A;

   // table: {address[6:0], data[7:0], expect_ack}
   localparam int NV = 5;
   localparam logic [15:0] WVEC [NV] = '{
      {7'h3A, 8'hA5, 1'b1},
      {7'h3A, 8'h00, 1'b1},
      {7'h55, 8'h12, 1'b0},
      {7'h3A, 8'hFF, 1'b1},
      {7'h3B, 8'h34, 1'b0}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       wr_tx = 1'b0;
   logic [7:0] tx_data = 8'h00;
   logic       rd_rx = 1'b0;
   logic       rd_stat = 1'b0;
   logic       sda_oe;
   logic [7:0] rx_data;
   logic       acc_active, acc_dir, acc_end, rx_rdy, tx_rdy, rx_ovr;
   logic       sda_bus;

   int n_cmp = 0;
   int n_bad = 0;
   int end_cnt = 0;

   always #2.5 clk = ~clk;

   assign sda_bus = sda_m & ~sda_oe;

   i2c_target_ctrl i_i2c_target_ctrl (
      .clk(clk), .rst_n(rst_n), .own_addr(MY_ADDR),
      .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
      .wr_tx(wr_tx), .tx_data(tx_data), .rd_rx(rd_rx), .rx_data(rx_data),
      .rd_stat(rd_stat), .acc_active(acc_active), .acc_dir(acc_dir),
      .acc_end(acc_end), .rx_rdy(rx_rdy), .tx_rdy(tx_rdy), .rx_ovr(rx_ovr)
   );

   always @(posedge clk) if (acc_end) end_cnt <= end_cnt + 1;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; scl_m = 1'b1; wq();
      sda_m = 1'b0; wq();
      scl_m = 1'b0; wq();
   endtask

   task automatic bus_restart();
      sda_m = 1'b1; wq();
      scl_m = 1'b1; wq();
      sda_m = 1'b0; wq();
      scl_m = 1'b0; wq();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wq();
      scl_m = 1'b1; wq();
      sda_m = 1'b1; wq();
   endtask

   task automatic put_bit(input logic b);
      sda_m = b; wq();
      scl_m = 1'b1; wq();
      wq();
      scl_m = 1'b0; wq();
   endtask

   task automatic get_bit(output logic b);
      sda_m = 1'b1; wq();
      scl_m = 1'b1; wq();
      b = sda_bus; wq();
      scl_m = 1'b0; wq();
   endtask

   task automatic send_byte(input logic [7:0] d, output logic acked);
      logic b;
      for (int i = 7; i >= 0; i--) put_bit(d[i]);
      get_bit(b);
      acked = ~b;
   endtask

   task automatic recv_byte(output logic [7:0] d, input logic give_ack);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         d[i] = b;
      end
      put_bit(~give_ack);
   endtask

   task automatic strobe_rx();
      @(negedge clk) rd_rx = 1'b1;
      @(negedge clk) rd_rx = 1'b0;
   endtask

   task automatic strobe_stat();
      @(negedge clk) rd_stat = 1'b1;
      @(negedge clk) rd_stat = 1'b0;
   endtask

   task automatic write_thr(input logic [7:0] d);
      @(negedge clk) begin wr_tx = 1'b1; tx_data = d; end
      @(negedge clk) wr_tx = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic       ack;
      logic [7:0] got;
      int         e0;

      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R1: reset state
      chk("R1 acc_active", acc_active, 0);
      chk("R1 acc_end", acc_end, 0);
      chk("R1 rx_rdy", rx_rdy, 0);
      chk("R1 rx_ovr", rx_ovr, 0);
      chk("R1 sda_oe", sda_oe, 0);
      chk("R1 tx_rdy", tx_rdy, 1);

      // table of write transfers
      for (int v = 0; v < NV; v++) begin
         e0 = end_cnt;
         bus_start();
         send_byte({WVEC[v][15:9], 1'b0}, ack);
         chk("R2 R3 address ack", ack, WVEC[v][0]);
         if (WVEC[v][0]) begin
            chk("R2 acc_active", acc_active, 1);
            chk("R2 acc_dir write", acc_dir, 0);
            send_byte(WVEC[v][8:1], ack);
            chk("R4 data ack", ack, 1);
            chk("R4 rx_rdy set", rx_rdy, 1);
            chk("R4 rx_data", rx_data, WVEC[v][8:1]);
            strobe_rx();
            chk("R4 rx_rdy cleared", rx_rdy, 0);
            bus_stop();
            chk("R9 end pulse on stop", end_cnt, e0 + 1);
            chk("R9 acc_active cleared", acc_active, 0);
         end else begin
            chk("R3 no access", acc_active, 0);
            bus_stop();
            chk("R9 no end pulse when idle", end_cnt, e0);
            chk("R3 nothing received", rx_rdy, 0);
         end
      end

      // R6 R7 R8: master read
      write_thr(8'hC3);
      e0 = end_cnt;
      bus_start();
      send_byte({MY_ADDR, 1'b1}, ack);
      chk("R2 read address ack", ack, 1);
      chk("R2 acc_dir read", acc_dir, 1);
      chk("R6 tx_rdy cleared on load", tx_rdy, 0);
      recv_byte(got, 1'b1);
      chk("R6 first read byte", got, 8'hC3);
      chk("R6 tx_rdy cleared by next load", tx_rdy, 0);
      recv_byte(got, 1'b0);
      chk("R7 fill byte", got, 8'hFF);
      chk("R6 tx_rdy set after nack", tx_rdy, 1);
      chk("R8 sda released", sda_oe, 0);
      wq();
      chk("R8 sda released later", sda_bus, 1);
      bus_stop();
      chk("R9 end pulse after read", end_cnt, e0 + 1);

      // R9: repeated start, same address then different address
      write_thr(8'h77);
      e0 = end_cnt;
      bus_start();
      send_byte({MY_ADDR, 1'b0}, ack);
      send_byte(8'h5C, ack);
      bus_restart();
      send_byte({MY_ADDR, 1'b1}, ack);
      chk("R9 same address ack", ack, 1);
      chk("R9 access kept", acc_active, 1);
      chk("R9 direction updated", acc_dir, 1);
      chk("R9 no end on same address", end_cnt, e0);
      recv_byte(got, 1'b0);
      chk("R7 written byte sent", got, 8'h77);
      bus_restart();
      send_byte({7'h11, 1'b0}, ack);
      chk("R3 other address nack", ack, 0);
      chk("R9 access cleared on miss", acc_active, 0);
      chk("R9 end pulse on miss", end_cnt, e0 + 1);
      chk("R4 data kept", rx_data, 8'h5C);
      bus_stop();
      chk("R9 no second end", end_cnt, e0 + 1);
      strobe_rx();

      // R5: overrun
      bus_start();
      send_byte({MY_ADDR, 1'b0}, ack);
      send_byte(8'h11, ack);
      chk("R5 no overrun yet", rx_ovr, 0);
      send_byte(8'h22, ack);
      chk("R5 overrun set", rx_ovr, 1);
      chk("R5 overwritten data", rx_data, 8'h22);
      chk("R5 rx_rdy held", rx_rdy, 1);
      bus_stop();
      strobe_stat();
      chk("R5 overrun cleared", rx_ovr, 0);
      strobe_rx();
      chk("R4 rx_rdy cleared after overrun", rx_rdy, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule